// File: doc/BRIEF.md
# Arithmetic Logic Shift Unit

This block is a purely combinational datapath element that folds an adder-based arithmetic section, a bitwise logic section and a one-place shifter into a single result multiplexer. Two operand words `a_in` and `b_in` of `W` bits enter together with a four-bit operation select, a carry input and two serial fill bits. The block produces a `W`-bit result and a carry output in the same cycle, with no state.

The top two select bits pick the section. In the arithmetic section the low select pair decides what is added to `a_in`: zero, `b_in`, the bitwise inverse of `b_in`, or all ones. The carry input is added at bit 0 and ripples upward. This gives eight operations: transfer, increment, add, add with carry, subtract with borrow, subtract, decrement and a second transfer. In the logic section the low pair picks AND, OR, XOR or inversion of `a_in`. The two shift codes move `a_in` one place up or down the index range, and a serial fill bit enters the vacated end.

The datapath has no clock, so the stream style does not apply to it. The block sits between register-file read ports and a destination register, and the surrounding pipeline owns all timing.

Top module: `arith_logic_shift_unit`

## Requirements
- R1: With `op_sel[3:2]` = 00 the result is `a_in + Y + carry_in` modulo 2^W, where Y is 0, `b_in`, `~b_in` or all ones for `op_sel[1:0]` = 00, 01, 10, 11.
- R2: In the arithmetic section `carry_out` is the carry out of bit W-1 of that sum. For example, incrementing (`op_sel` = 0000, `carry_in` = 1) sets it only when `a_in` is all ones.
- R3: `op_sel` = 0010 with `carry_in` = 1 gives `a_in - b_in` and `carry_out` = 1 exactly when `a_in >= b_in` (unsigned). With `carry_in` = 0 it gives `a_in - b_in - 1`.
- R4: `op_sel` = 0011 with `carry_in` = 0 gives `a_in - 1`. With `carry_in` = 1 it gives `a_in` unchanged with `carry_out` = 1. `op_sel` = 0000 with `carry_in` = 0 passes `a_in` with `carry_out` = 0.
- R5: With `op_sel[3:2]` = 01 the result is `a_in & b_in`, `a_in | b_in`, `a_in ^ b_in` or `~a_in` for `op_sel[1:0]` = 00, 01, 10, 11.
- R6: `carry_in` has no effect on the result in the logic and shift sections.
- R7: With `op_sel[3:2]` = 10, result bit 0 equals `fill_lo` and result bit k (k >= 1) equals `a_in[k-1]`.
- R8: With `op_sel[3:2]` = 11, result bit W-1 equals `fill_hi` and result bit k (k <= W-2) equals `a_in[k+1]`.
- R9: `op_sel[1:0]` has no effect on the result in either shift code.
- R10: `carry_out` is 0 whenever `op_sel[3:2]` is not 00.
- R11: `fill_lo` and `fill_hi` have no effect on the result or `carry_out` in the arithmetic and logic sections.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | W | First operand; the one shifted, incremented or inverted |
| b_in | input | W | Second operand for the two-operand operations |
| op_sel | input | 4 | Operation select: [3:2] picks the section, [1:0] the operation within it |
| carry_in | input | 1 | Carry into bit 0 of the arithmetic section |
| fill_lo | input | 1 | Serial bit entering bit 0 on the upward shift |
| fill_hi | input | 1 | Serial bit entering bit W-1 on the downward shift |
| result | output | W | Operation result |
| carry_out | output | 1 | Arithmetic carry out of the top bit; 0 outside the arithmetic section |

## Verification
The in-line assertions assume that every input is a known 0 or 1 and that W is at least 2. Each check is skipped while any operand or select still carries an unknown value, so the undriven instant at time zero raises nothing. The bench drives every input from its first statement and changes them only on the falling clock edge. It samples the outputs a quarter period later, after the combinational paths have settled. All 256 operand pairs are applied for every arithmetic and logic code and both carry values, and the shift codes are swept over every operand, fill and low-select combination.

// File: rtl/als_pkg.sv
package als_pkg;
  typedef enum logic [1:0] {
    SEC_ARITH = 2'b00,
    SEC_LOGIC = 2'b01,
    SEC_UP    = 2'b10,
    SEC_DOWN  = 2'b11
  } section_e;

  typedef enum logic [1:0] {
    ADDEND_ZERO = 2'b00,
    ADDEND_B    = 2'b01,
    ADDEND_NOTB = 2'b10,
    ADDEND_ONES = 2'b11
  } addend_e;

  typedef enum logic [1:0] {
    LOP_AND  = 2'b00,
    LOP_OR   = 2'b01,
    LOP_XOR  = 2'b10,
    LOP_NOTA = 2'b11
  } logic_op_e;
endpackage

// File: rtl/als_arith.sv
module als_arith
  import als_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   sub_sel,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  localparam int CW = W + 1;

  logic [W:0]   carry;
  logic [W-1:0] addend;

  assign carry[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_stage
    always_comb begin
      unique case (addend_e'(sub_sel))
        ADDEND_ZERO: addend[i] = 1'b0;
        ADDEND_B:    addend[i] = b[i];
        ADDEND_NOTB: addend[i] = ~b[i];
        default:     addend[i] = 1'b1;
      endcase
    end
    assign sum[i]     = a[i] ^ addend[i] ^ carry[i];
    assign carry[i+1] = (a[i] & addend[i]) | (carry[i] & (a[i] ^ addend[i]));
  end

  assign cout = carry[W];

  always_comb begin
    if (!$isunknown({a, b, sub_sel, cin})) begin
      if (sub_sel == 2'b01) begin
        a_r1_add: assert ({cout, sum} == (CW'(a) + CW'(b) + CW'(cin)))
          else $error("R1 add mismatch");
      end
      if (sub_sel == 2'b10 && cin) begin
        a_r3_sub: assert (sum == W'(a - b) && cout == (a >= b))
          else $error("R3 subtract mismatch");
      end
      if (sub_sel == 2'b11 && !cin) begin
        a_r4_dec: assert (sum == W'(a - W'(1)))
          else $error("R4 decrement mismatch");
      end
      if (sub_sel == 2'b00 && cin) begin
        a_r2_inc_carry: assert (cout == (&a))
          else $error("R2 increment carry mismatch");
      end
    end
  end
endmodule

// File: rtl/als_logic.sv
module als_logic
  import als_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   lop,
  output logic [W-1:0] res
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      unique case (logic_op_e'(lop))
        LOP_AND:  res[i] = a[i] & b[i];
        LOP_OR:   res[i] = a[i] | b[i];
        LOP_XOR:  res[i] = a[i] ^ b[i];
        default:  res[i] = ~a[i];
      endcase
    end
  end

  always_comb begin
    if (!$isunknown({a, b, lop})) begin
      if (lop == 2'b11) begin
        a_r5_invert: assert ((res ^ a) == {W{1'b1}})
          else $error("R5 invert mismatch");
      end
      if (lop == 2'b10) begin
        a_r5_xor: assert ((res ^ b) == a)
          else $error("R5 xor mismatch");
      end
      if (lop == 2'b00) begin
        a_r5_and: assert ((res & ~a) == '0 && (res & ~b) == '0)
          else $error("R5 and mismatch");
      end
    end
  end
endmodule

// File: rtl/als_shift.sv
module als_shift #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic         fill_lo,
  input  logic         fill_hi,
  output logic [W-1:0] up,
  output logic [W-1:0] down
);
  for (genvar i = 0; i < W; i++) begin : g_tap
    if (i == 0) begin : g_low
      assign up[i]   = fill_lo;
      assign down[i] = a[i+1];
    end else if (i == W - 1) begin : g_high
      assign up[i]   = a[i-1];
      assign down[i] = fill_hi;
    end else begin : g_mid
      assign up[i]   = a[i-1];
      assign down[i] = a[i+1];
    end
  end

  always_comb begin
    if (!$isunknown({a, fill_lo, fill_hi})) begin
      a_r7_up_count: assert ($countones(up) == $countones(a[W-2:0]) + int'(fill_lo))
        else $error("R7 upward shift loses bits");
      a_r8_down_count: assert ($countones(down) == $countones(a[W-1:1]) + int'(fill_hi))
        else $error("R8 downward shift loses bits");
    end
  end
endmodule

// File: rtl/arith_logic_shift_unit.sv
module arith_logic_shift_unit
  import als_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [3:0]   op_sel,
  input  logic         carry_in,
  input  logic         fill_lo,
  input  logic         fill_hi,
  output logic [W-1:0] result,
  output logic         carry_out
);
  section_e     sect;
  logic [W-1:0] ar_sum, lg_res, sh_up, sh_down;
  logic         ar_cout;

  assign sect = section_e'(op_sel[3:2]);

  als_arith #(.W(W)) u_arith (
    .a(a_in), .b(b_in), .sub_sel(op_sel[1:0]), .cin(carry_in),
    .sum(ar_sum), .cout(ar_cout)
  );

  als_logic #(.W(W)) u_logic (
    .a(a_in), .b(b_in), .lop(op_sel[1:0]), .res(lg_res)
  );

  als_shift #(.W(W)) u_shift (
    .a(a_in), .fill_lo(fill_lo), .fill_hi(fill_hi),
    .up(sh_up), .down(sh_down)
  );

  always_comb begin
    unique case (sect)
      SEC_ARITH: result = ar_sum;
      SEC_LOGIC: result = lg_res;
      SEC_UP:    result = sh_up;
      default:   result = sh_down;
    endcase
  end

  assign carry_out = (sect == SEC_ARITH) & ar_cout;

  always_comb begin
    if (!$isunknown({a_in, b_in, op_sel, carry_in, fill_lo, fill_hi})) begin
      if (op_sel[3:2] != 2'b00) begin
        a_r10_no_carry: assert (!carry_out)
          else $error("R10 carry outside arithmetic");
      end
      if (op_sel == 4'b0011 && carry_in) begin
        a_r4_pass: assert (result == a_in && carry_out)
          else $error("R4 pass-through mismatch");
      end
    end
  end
endmodule

// File: tb/tb_arith_logic_shift_unit.sv
module tb_arith_logic_shift_unit;
  localparam int W = 4;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic         clk = 1'b0;
  logic [W-1:0] a_in, b_in, result;
  logic [3:0]   op_sel;
  logic         carry_in, fill_lo, fill_hi, carry_out;
  int           n_vec = 0;
  int           n_bad = 0;

  always #10 clk = ~clk;

  arith_logic_shift_unit #(.W(W)) dut (
    .a_in(a_in), .b_in(b_in), .op_sel(op_sel), .carry_in(carry_in),
    .fill_lo(fill_lo), .fill_hi(fill_hi), .result(result), .carry_out(carry_out)
  );

  function automatic logic [W:0] model(logic [W-1:0] a, logic [W-1:0] b,
                                       logic [3:0] s, logic c, logic lo, logic hi);
    logic [W-1:0] y;
    logic [W:0]   t;
    case (s[3:2])
      2'b00: begin
        case (s[1:0])
          2'b00: y = '0;
          2'b01: y = b;
          2'b10: y = ~b;
          default: y = ONES;
        endcase
        t = {1'b0, a} + {1'b0, y} + {{W{1'b0}}, c};
        return t;
      end
      2'b01: begin
        case (s[1:0])
          2'b00: return {1'b0, a & b};
          2'b01: return {1'b0, a | b};
          2'b10: return {1'b0, a ^ b};
          default: return {1'b0, ~a};
        endcase
      end
      2'b10: return {1'b0, a[W-2:0], lo};
      default: return {1'b0, hi, a[W-1:1]};
    endcase
  endfunction

  task automatic drive(logic [W-1:0] a, logic [W-1:0] b, logic [3:0] s,
                       logic c, logic lo, logic hi);
    @(negedge clk);
    a_in = a; b_in = b; op_sel = s; carry_in = c; fill_lo = lo; fill_hi = hi;
    #5;
  endtask

  task automatic check(string req, logic [W-1:0] exp_f, logic exp_c);
    n_vec++;
    if (result !== exp_f || carry_out !== exp_c) begin
      n_bad++;
      $display("FAIL %s: op=%b cin=%b a=%h b=%h got result=%h carry=%b expected result=%h carry=%b",
               req, op_sel, carry_in, a_in, b_in, result, carry_out, exp_f, exp_c);
    end
  endtask

  task automatic run_model(string req, logic [W-1:0] a, logic [W-1:0] b,
                           logic [3:0] s, logic c, logic lo, logic hi);
    logic [W:0] e;
    drive(a, b, s, c, lo, hi);
    e = model(a, b, s, c, lo, hi);
    check(req, e[W-1:0], e[W]);
  endtask

  // R1 R2: quiet inputs give a zero result
  task automatic t_idle;
    drive('0, '0, 4'b0000, 1'b0, 1'b0, 1'b0);
    check("R1 idle", '0, 1'b0);
  endtask

  // R1 R2: every arithmetic code, both carries, every operand pair
  task automatic t_arith_sweep;
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 2; c++)
        for (int a = 0; a < 16; a++)
          for (int b = 0; b < 16; b++)
            run_model("R1/R2 arith", W'(a), W'(b), {2'b00, 2'(s)}, 1'(c), 1'b0, 1'b0);
  endtask

  // R3 R4 R2: literal corner values
  task automatic t_corners;
    drive(4'd5, 4'd3, 4'b0010, 1'b1, 1'b0, 1'b0); check("R3 5-3", 4'd2, 1'b1);
    drive(4'd3, 4'd5, 4'b0010, 1'b1, 1'b0, 1'b0); check("R3 3-5", 4'd14, 1'b0);
    drive(4'd7, 4'd7, 4'b0010, 1'b1, 1'b0, 1'b0); check("R3 7-7", 4'd0, 1'b1);
    drive(4'd5, 4'd3, 4'b0010, 1'b0, 1'b0, 1'b0); check("R3 5-3-1", 4'd1, 1'b1);
    drive(4'd15, 4'd0, 4'b0000, 1'b1, 1'b0, 1'b0); check("R2 inc wrap", 4'd0, 1'b1);
    drive(4'd14, 4'd0, 4'b0000, 1'b1, 1'b0, 1'b0); check("R2 inc", 4'd15, 1'b0);
    drive(4'd0, 4'd9, 4'b0011, 1'b0, 1'b0, 1'b0); check("R4 dec zero", 4'd15, 1'b0);
    drive(4'd8, 4'd9, 4'b0011, 1'b0, 1'b0, 1'b0); check("R4 dec", 4'd7, 1'b1);
    drive(4'd9, 4'd2, 4'b0011, 1'b1, 1'b0, 1'b0); check("R4 pass ones", 4'd9, 1'b1);
    drive(4'd9, 4'd2, 4'b0000, 1'b0, 1'b0, 1'b0); check("R4 pass zero", 4'd9, 1'b0);
    drive(4'd9, 4'd8, 4'b0001, 1'b1, 1'b0, 1'b0); check("R2 add carry", 4'd2, 1'b1);
  endtask

  // R5 R6 R10: logic codes with both carry values
  task automatic t_logic_sweep;
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 2; c++)
        for (int a = 0; a < 16; a++)
          for (int b = 0; b < 16; b++)
            run_model("R5/R6/R10 logic", W'(a), W'(b), {2'b01, 2'(s)}, 1'(c), 1'b0, 1'b0);
  endtask

  // R7 R8 R9 R6 R10: shifts over every operand, fill, low select and carry
  task automatic t_shift_sweep;
    for (int d = 2; d < 4; d++)
      for (int s = 0; s < 4; s++)
        for (int c = 0; c < 2; c++)
          for (int f = 0; f < 4; f++)
            for (int a = 0; a < 16; a++)
              run_model(d == 2 ? "R7/R9 shift up" : "R8/R9 shift down",
                        W'(a), W'(a ^ 5), {2'(d), 2'(s)}, 1'(c), f[0], f[1]);
    drive(4'b1001, '0, 4'b1000, 1'b1, 1'b1, 1'b0); check("R7 literal", 4'b0011, 1'b0);
    drive(4'b1001, '0, 4'b1111, 1'b1, 1'b0, 1'b1); check("R8 literal", 4'b1100, 1'b0);
  endtask

  // R11: fill inputs toggled in arithmetic and logic sections
  task automatic t_fill_ignored;
    for (int s = 0; s < 8; s++)
      for (int f = 1; f < 4; f++)
        for (int a = 0; a < 16; a += 3)
          run_model("R11 fill ignored", W'(a), W'(15 - a), 4'(s), 1'(a & 1), f[0], f[1]);
  endtask

  initial begin
    a_in = '0; b_in = '0; op_sel = '0; carry_in = 1'b0; fill_lo = 1'b0; fill_hi = 1'b0;
    t_idle();
    t_arith_sweep();
    t_corners();
    t_logic_sweep();
    t_shift_sweep();
    t_fill_ignored();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule